// File: doc/BRIEF.md
# Bus Machine-Cycle Capture Encoder

This block sits beside an 8-bit processor with a multiplexed address/data bus and watches only its status and strobe pins: the memory/IO select, the two status bits S1 and S0, and the active-low read, write and interrupt-acknowledge strobes. Each machine cycle is classified from these pins, and one 3-bit cycle code is issued per completed cycle together with a one-clock valid pulse. The result is a compact stream of codes that describes what the processor is doing, cycle by cycle, without looking at address or data.

All inputs are treated as synchronous to the processor clock. A cycle starts on the first clock where any strobe is sampled low. The status seen on that clock is frozen and used for the code, and the code is issued when the strobes are released. A long stretch with no strobe and both status bits low is reported once as a halt. An optional serial port repeats every issued code, one bit per clock with a frame flag, for a narrow link to a downstream checker.

Top module: `mcyc_capture`

## Requirements
- R1: While rst_ni is low, valid_o and ser_frame_o are low. A cycle whose strobe was active when reset arrived issues no code after reset is released.
- R2: A code is issued exactly once per cycle. valid_o is high for one clock, in the clock after the first sampled edge where rd_ni, wr_ni and inta_ni are all high following an edge where at least one was low. valid_o is never high on two consecutive clocks.
- R3: Opcode fetch gives code 000. At the cycle's first strobe clock the pins are io_m_i=0, s1_i=1, s0_i=1, rd_ni=0, wr_ni=1 and inta_ni=1.
- R4: Memory read gives 011 (io_m_i=0, s1_i=1, s0_i=0, only rd_ni low). Memory write gives 100 (io_m_i=0, s1_i=0, s0_i=1, only wr_ni low).
- R5: I/O read gives 001 (io_m_i=1, s1_i=1, s0_i=0, only rd_ni low). I/O write gives 010 (io_m_i=1, s1_i=0, s0_i=1, only wr_ni low).
- R6: Any other pin combination at the first strobe clock gives 111. This includes interrupt acknowledge (io_m_i=1, s1_i=1, s0_i=1, only inta_ni low), more than one strobe low at once, and a strobe with unmatching status. Code 101 is never issued.
- R7: Status is taken on the first clock of a strobe. Changes to io_m_i, s1_i, s0_i or to which strobe is low during the rest of that strobe do not alter the code.
- R8: After HALT_CLKS consecutive sampled edges with all strobes high and s1_i=s0_i=0, code 110 is issued once, in the clock after the last of those edges. No further halt code is issued until an edge with a strobe low or with s1_i or s0_i high.
- R9: Fewer than HALT_CLKS such idle edges issue nothing. A strobe-release edge whose status already reads s1_i=s0_i=0 counts as the first idle edge.
- R10: With SER_EN=1, each issued code is shifted out on ser_o MSB first, starting the clock after valid_o. ser_frame_o is high for exactly those three clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_m_i | input | 1 | Memory (0) / I/O (1) select |
| s1_i | input | 1 | Status bit 1 |
| s0_i | input | 1 | Status bit 0 |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| inta_ni | input | 1 | Interrupt acknowledge strobe, active low |
| code_o | output | 3 | Cycle code, meaningful while valid_o is high |
| valid_o | output | 1 | One-clock pulse per issued code |
| ser_o | output | 1 | Serial code bit, MSB first |
| ser_frame_o | output | 1 | High while ser_o carries a code bit |

## Verification
Two functions can act on the same clock edge: issuing a code on strobe release, and counting idle clocks toward a halt. The bench provokes this by releasing a memory read with both status bits already low. It then expects the read code right after that edge and the halt code exactly HALT_CLKS-1 edges later, with silence in between. An off-by-one in either path shows up as a halt code issued one clock early or one clock late.

// File: rtl/mcyc_pkg.sv
`timescale 1ns/1ps
package mcyc_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    CY_FETCH = 3'd0,
    CY_IORD  = 3'd1,
    CY_IOWR  = 3'd2,
    CY_MRD   = 3'd3,
    CY_MWR   = 3'd4,
    CY_IDLE  = 3'd5,
    CY_HALT  = 3'd6,
    CY_OTHER = 3'd7
  } cyc_code_e;
endpackage

// File: rtl/mcyc_classify.sv
`timescale 1ns/1ps
module mcyc_classify
  import mcyc_pkg::*;
(
  input  logic      io_m_i,
  input  logic      s1_i,
  input  logic      s0_i,
  input  logic      rd_ni,
  input  logic      wr_ni,
  input  logic      inta_ni,
  output cyc_code_e code_o
);
  logic [5:0] pins;
  assign pins = {io_m_i, s1_i, s0_i, rd_ni, wr_ni, inta_ni};

  // exact match on status plus a single active strobe; all else is "other"
  always_comb begin
    unique case (pins)
      6'b011_011: code_o = CY_FETCH;
      6'b010_011: code_o = CY_MRD;
      6'b001_101: code_o = CY_MWR;
      6'b110_011: code_o = CY_IORD;
      6'b101_101: code_o = CY_IOWR;
      default:    code_o = CY_OTHER;
    endcase
  end
endmodule

// File: rtl/mcyc_track.sv
`timescale 1ns/1ps
module mcyc_track
  import mcyc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      strobe_i,
  input  cyc_code_e code_i,
  output logic      release_o,
  output cyc_code_e cap_o
);
  logic      act_q;
  cyc_code_e cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cap_q <= CY_OTHER;
    end else begin
      act_q <= strobe_i;
      if (strobe_i && !act_q) cap_q <= code_i;
    end
  end

  assign release_o = act_q && !strobe_i;
  assign cap_o     = cap_q;

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && strobe_i) |=> $stable(cap_q));
endmodule

// File: rtl/mcyc_halt.sv
`timescale 1ns/1ps
module mcyc_halt #(
  parameter int HALT_CLKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  output logic fire_o
);
  localparam int CNT_W = $clog2(HALT_CLKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALT_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             halted_q;

  assign fire_o = idle_i && !halted_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      halted_q <= 1'b0;
    end else if (!idle_i) begin
      cnt_q    <= '0;
      halted_q <= 1'b0;
    end else if (fire_o) begin
      halted_q <= 1'b1;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_halt_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/mcyc_ser.sv
`timescale 1ns/1ps
module mcyc_ser
  import mcyc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              ser_o,
  output logic              ser_frame_o
);
  localparam int LW = $clog2(CODE_W + 1);
  localparam logic [LW-1:0] FULL = LW'(CODE_W);

  logic [CODE_W-1:0] sh_q;
  logic [LW-1:0]     left_q;

  // a new load restarts the frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= code_i;
      left_q <= FULL;
    end else if (left_q != '0) begin
      sh_q   <= {sh_q[CODE_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign ser_o       = sh_q[CODE_W-1];
  assign ser_frame_o = (left_q != '0);

  p_frame_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ser_frame_o && ser_o == $past(code_i[CODE_W-1])));
endmodule

// File: rtl/mcyc_capture.sv
`timescale 1ns/1ps
module mcyc_capture
  import mcyc_pkg::*;
#(
  parameter int HALT_CLKS = 8,
  parameter bit SER_EN    = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        io_m_i,
  input  logic        s1_i,
  input  logic        s0_i,
  input  logic        rd_ni,
  input  logic        wr_ni,
  input  logic        inta_ni,
  output logic [2:0]  code_o,
  output logic        valid_o,
  output logic        ser_o,
  output logic        ser_frame_o
);
  cyc_code_e cls_code, cap_code, code_q;
  logic      strobe, idle, rel, halt_fire, valid_q;

  assign strobe = !rd_ni || !wr_ni || !inta_ni;
  assign idle   = !strobe && !s1_i && !s0_i;

  mcyc_classify u_cls (
    .io_m_i (io_m_i), .s1_i (s1_i), .s0_i (s0_i),
    .rd_ni  (rd_ni),  .wr_ni (wr_ni), .inta_ni (inta_ni),
    .code_o (cls_code)
  );

  mcyc_track u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe),
    .code_i    (cls_code),
    .release_o (rel),
    .cap_o     (cap_code)
  );

  mcyc_halt #(.HALT_CLKS(HALT_CLKS)) u_halt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idle_i (idle),
    .fire_o (halt_fire)
  );

  // release and halt cannot coincide while HALT_CLKS >= 4
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      code_q  <= CY_OTHER;
    end else begin
      valid_q <= rel || halt_fire;
      if (rel)            code_q <= cap_code;
      else if (halt_fire) code_q <= CY_HALT;
    end
  end

  assign valid_o = valid_q;
  assign code_o  = code_q;

  generate
    if (SER_EN) begin : g_ser
      mcyc_ser u_ser (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (valid_q),
        .code_i      (code_q),
        .ser_o       (ser_o),
        .ser_frame_o (ser_frame_o)
      );
    end else begin : g_no_ser
      assign ser_o       = 1'b0;
      assign ser_frame_o = 1'b0;
    end
  endgenerate

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_no_idle_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (code_o != CY_IDLE));
endmodule

// File: tb/mcyc_capture_test.sv
`timescale 1ns/1ps
module mcyc_capture_test;
  localparam int HC = 8;
  localparam logic [5:0] BUS_IDLE = 6'b010_111;  // no strobe, not halt status
  localparam logic [5:0] BUS_HALT = 6'b000_111;

  // {io_m,s1,s0,rd_n,wr_n,inta_n, expected code}
  localparam logic [8:0] VEC [9] = '{
    {6'b011_011, 3'b000},  // R3 fetch
    {6'b010_011, 3'b011},  // R4 mem read
    {6'b001_101, 3'b100},  // R4 mem write
    {6'b110_011, 3'b001},  // R5 io read
    {6'b101_101, 3'b010},  // R5 io write
    {6'b111_110, 3'b111},  // R6 interrupt ack
    {6'b010_001, 3'b111},  // R6 two strobes low
    {6'b011_101, 3'b111},  // R6 fetch status with write strobe
    {6'b000_011, 3'b111}   // R6 halt status with read strobe
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic io_m, s1, s0, rd_n, wr_n, inta_n;
  logic [2:0] code;
  logic valid, ser, frame;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mcyc_capture #(.HALT_CLKS(HC), .SER_EN(1'b1)) uut (
    .clk_i (clk), .rst_ni (rst_ni),
    .io_m_i (io_m), .s1_i (s1), .s0_i (s0),
    .rd_ni (rd_n), .wr_ni (wr_n), .inta_ni (inta_n),
    .code_o (code), .valid_o (valid), .ser_o (ser), .ser_frame_o (frame)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] b);
    {io_m, s1, s0, rd_n, wr_n, inta_n} = b;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe for 3 edges, release to rel_bus, check code after release edge
  task automatic bus_cycle(input logic [5:0] b, input logic [2:0] exp,
                           input logic [5:0] rel_bus, input string tag);
    drive(b);
    step(3);
    drive(rel_bus);
    step(1);
    chk(tag, {valid, code}, {1'b1, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    drive(BUS_IDLE);
    step(2);
    chk("R1 reset valid", {3'b0, valid}, 4'h0);
    chk("R1 reset frame", {3'b0, frame}, 4'h0);
    rst_ni = 1'b1;
    step(2);
    chk("R2 idle no code", {3'b0, valid}, 4'h0);

    // table walk
    for (int i = 0; i < 9; i++) begin
      bus_cycle(VEC[i][8:3], VEC[i][2:0], BUS_IDLE, "R3/R4/R5/R6 code");
      step(1);
      chk("R2 single pulse", {3'b0, valid}, 4'h0);
      step(2);
    end

    // R7: status changes mid-strobe are ignored
    drive(6'b010_011);
    step(1);
    drive(6'b101_101);
    step(2);
    drive(BUS_IDLE);
    step(1);
    chk("R7 frozen status", {valid, code}, {1'b1, 3'b011});
    step(4);

    // R10: serial frame of memory write then I/O read
    bus_cycle(6'b001_101, 3'b100, BUS_IDLE, "R4 mw before serial");
    step(1); chk("R10 bit2", {2'b0, frame, ser}, 4'b0011);
    step(1); chk("R10 bit1", {2'b0, frame, ser}, 4'b0010);
    step(1); chk("R10 bit0", {2'b0, frame, ser}, 4'b0010);
    step(1); chk("R10 frame end", {3'b0, frame}, 4'h0);
    step(2);
    bus_cycle(6'b110_011, 3'b001, BUS_IDLE, "R5 ior before serial");
    step(1); chk("R10 bit2", {2'b0, frame, ser}, 4'b0010);
    step(1); chk("R10 bit1", {2'b0, frame, ser}, 4'b0010);
    step(1); chk("R10 bit0", {2'b0, frame, ser}, 4'b0011);
    step(1); chk("R10 frame end", {3'b0, frame}, 4'h0);
    step(2);

    // R9: one idle edge short of the halt window
    drive(BUS_HALT);
    for (int k = 1; k < HC; k++) begin
      step(1);
      chk("R9 short idle", {3'b0, valid}, 4'h0);
    end
    drive(BUS_IDLE);
    step(1);
    chk("R9 short idle end", {3'b0, valid}, 4'h0);

    // R8: full window issues halt once, then stays silent
    drive(BUS_HALT);
    for (int k = 1; k < HC; k++) step(1);
    step(1);
    chk("R8 halt code", {valid, code}, {1'b1, 3'b110});
    for (int k = 0; k < 10; k++) begin
      step(1);
      chk("R8 silent after halt", {3'b0, valid}, 4'h0);
    end
    drive(BUS_IDLE);
    step(1);
    drive(BUS_HALT);
    step(HC);
    chk("R8 halt re-armed", {valid, code}, {1'b1, 3'b110});
    drive(BUS_IDLE);
    step(3);

    // R9: release edge with halt status is the first idle edge
    bus_cycle(6'b010_011, 3'b011, BUS_HALT, "R9 release into halt");
    for (int k = 1; k < HC - 1; k++) begin
      step(1);
      chk("R9 gap after release", {3'b0, valid}, 4'h0);
    end
    step(1);
    chk("R9 halt after release", {valid, code}, {1'b1, 3'b110});
    drive(BUS_IDLE);
    step(3);

    // R1: reset during an active strobe discards the cycle
    drive(6'b011_011);
    step(2);
    rst_ni = 1'b0;
    step(1);
    chk("R1 valid in reset", {3'b0, valid}, 4'h0);
    drive(BUS_IDLE);
    step(1);
    rst_ni = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step(1);
      chk("R1 no code after reset", {3'b0, valid}, 4'h0);
    end

    finish_run();
  end
endmodule